// File: doc/BRIEF.md
# Peripheral Clock Enable Bank

The block holds one clock-enable bit per peripheral identifier and drives the bits out as a vector, where bit n gates the clock of the peripheral whose identifier is n. In most systems this identifier is the same number as the peripheral's interrupt source. Software never rewrites the whole vector. A write to the set register turns on the clocks selected by the one-bits of the data. A write to the clear register turns off the clocks selected by the one-bits of the data. No read-modify-write sequence is needed, so two pieces of software that each manage their own peripherals cannot undo each other's changes.

A read-only status register returns the current enable vector. Turning a clock off takes effect on the enable output in the same cycle as the clear write, before the register updates. Turning a clock on takes effect from the next clock edge. Identifiers with no peripheral behind them are fixed at zero by a build-time mask.

Software must make sure a peripheral has finished its last operation before it turns that peripheral's clock off. The block does not exchange any handshake with the peripherals.

Top module: `pclk_gate_bank`

## Requirements
- R1: A write with reg_addr = 0x0 sets every implemented bit of the enable state whose reg_wdata bit is 1, and leaves bits whose reg_wdata bit is 0 unchanged. The new value is visible on clk_en from the next rising edge. Bit n belongs to peripheral identifier n.
- R2: A write with reg_addr = 0x4 clears every enable bit whose reg_wdata bit is 1, and leaves bits whose reg_wdata bit is 0 unchanged.
- R3: A read with reg_addr = 0x8 returns the enable state, with bit n holding the state of peripheral n.
- R4: After reset, every enable bit and every clk_en bit is 0.
- R5: During a clear write, the selected clk_en bits are already 0 in the same cycle as the strobe, before the next clock edge.
- R6: A bit whose IMPL_MASK bit is 0 always reads as 0, both on clk_en and in the status register, whatever has been written.
- R7: Reads at 0x0, 0x4 and any other offset except 0x8 return 0, and writes to offsets other than 0x0 and 0x4 leave the enable state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Byte offset of the register being accessed |
| reg_wdata | input | NIDS | Write data, one bit per peripheral identifier |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | NIDS | Read data, returned combinationally from reg_addr |
| clk_en | output | NIDS | Per-peripheral clock-enable vector |

## Verification
The assertions assume the following about the inputs:
- reg_addr, reg_wdata and reg_we are stable around each rising edge.
- rst_n is held low across at least one edge before release.
- reg_we marks exactly one write per strobed cycle.

The bench keeps within these assumptions by changing inputs only on the falling edge, and it samples a few nanoseconds later, which also lets it observe the same-cycle drop of a clear. The sweeps use a mask with gaps in it, so that writes to unimplemented identifiers are exercised on every pattern.

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank #(
  parameter int                 NIDS      = 32,
  parameter int                 AW        = 4,
  parameter logic [NIDS-1:0]    IMPL_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NIDS-1:0] reg_wdata,
  input  logic            reg_we,
  output logic [NIDS-1:0] reg_rdata,
  output logic [NIDS-1:0] clk_en
);

  localparam logic [AW-1:0] OFS_SET  = AW'(4'h0);
  localparam logic [AW-1:0] OFS_CLR  = AW'(4'h4);
  localparam logic [AW-1:0] OFS_STAT = AW'(4'h8);

  logic [NIDS-1:0] en_q;
  logic            hit_set, hit_clr;

  assign hit_set = reg_we && (reg_addr == OFS_SET);
  assign hit_clr = reg_we && (reg_addr == OFS_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (hit_set) en_q <= en_q | (reg_wdata & IMPL_MASK);
    else if (hit_clr) en_q <= en_q & ~reg_wdata;
  end

  assign clk_en    = hit_clr ? (en_q & ~reg_wdata) : en_q;
  assign reg_rdata = (reg_addr == OFS_STAT) ? en_q : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0)); // R4

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> ((en_q & $past(reg_wdata & IMPL_MASK)) == $past(reg_wdata & IMPL_MASK))); // R1

  AST_CLR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |-> ((clk_en & reg_wdata) == '0)); // R5

  AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((en_q & $past(reg_wdata)) == '0)); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_set || hit_clr) |=> (en_q == $past(en_q))); // R7

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en | reg_rdata) & ~IMPL_MASK) == '0); // R6

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != OFS_STAT) |-> (reg_rdata == '0)); // R7

endmodule

// File: tb/sim_pclk_gate_bank.sv
module sim_pclk_gate_bank;
  localparam int          N    = 32;
  localparam logic [31:0] MASK = 32'hF0FF_7FEE;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [3:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic          reg_we = 0;
  logic [N-1:0]  reg_rdata, clk_en;

  int checks = 0, failures = 0;
  logic [N-1:0] model = '0;
  logic [31:0]  lfsr = 32'hACE1_1234;
  bit done = 0;

  pclk_gate_bank #(.NIDS(N), .AW(4), .IMPL_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .clk_en(clk_en));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    #3;
    if (a == 4'h4) chk("R5 same-cycle clear", clk_en, model & ~d);
    else           chk("R1 enable unchanged before edge", clk_en, model);
    @(negedge clk);
    reg_we = 0;
    if (a == 4'h0)      model = model | (d & MASK);
    else if (a == 4'h4) model = model & ~d;
  endtask

  task automatic rd_status(string req);
    @(negedge clk);
    reg_addr = 4'h8;
    #3;
    chk(req, reg_rdata, model);
    chk(req, clk_en, model);
  endtask

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk("R4 clk_en in reset", clk_en, '0);
    @(negedge clk); rst_n = 1;
    rd_status("R4 status after reset");

    for (int i = 0; i < N; i++) begin
      wr(4'h0, 32'h1 << i);
      rd_status("R1 R3 R6 walking set");
    end
    wr(4'h0, '0);
    rd_status("R1 zero write no effect");

    for (int i = 0; i < N; i++) begin
      wr(4'h4, 32'h1 << i);
      rd_status("R2 walking clear");
    end
    wr(4'h0, '1);
    rd_status("R6 all-ones set masked");
    wr(4'h4, '0);
    rd_status("R2 zero clear no effect");

    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      reg_addr = 4'(a);
      #3;
      chk("R7 read decode", reg_rdata, (a == 8) ? model : '0);
    end
    for (int a = 1; a < 16; a++) begin
      if (a != 4) begin
        wr(4'(a), lfsr);
        lfsr = step(lfsr);
        rd_status("R7 write to other offset ignored");
      end
    end

    for (int k = 0; k < 200; k++) begin
      wr(lfsr[0] ? 4'h4 : 4'h0, step(lfsr));
      lfsr = step(step(lfsr));
      rd_status("R1 R2 R3 R5 pattern sweep");
    end

    @(negedge clk); rst_n = 0; model = '0;
    #3;
    chk("R4 reassert reset", clk_en, '0);
    @(negedge clk); rst_n = 1;
    rd_status("R4 status after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule